// File: doc/BRIEF.md
# Four-Phase Accumulator Processor

This block is a very small accumulator machine. It runs a program of up to eight 8-bit instruction words held in its own program store. Each instruction holds an operation code in its upper nibble and an immediate operand in its lower nibble. Every instruction takes the same four clock cycles, one for each phase T1 to T4, whatever its operation code. The operations load an immediate into the accumulator, add an immediate to the accumulator, copy the accumulator to an output register, or halt.

Software fills the program store through a simple write port while the run enable is low, pulses reset, and then raises run enable. The output register can be read at any time. The halted flag shows that the program has stopped, either on a halt instruction or after the last program slot has run.

Top module: `quad_phase_cpu`

## Requirements
- R1: Each instruction takes exactly four active cycles. Numbering active rising edges from 1 after reset, instruction k (counted from 0) commits its result on active edge 4k+4 and at no other edge.
- R2: An instruction word has the operation code in bits [7:4] and the immediate in bits [3:0]. Code 4'h1 writes the immediate, zero-extended to ACC_W bits, into the accumulator.
- R3: Code 4'h2 adds the zero-extended immediate to the accumulator modulo 2^ACC_W. The carry output takes the carry-out of that sum. No other code changes the carry.
- R4: Code 4'h3 copies the accumulator into the output register. The output register holds its value at all other times.
- R5: Every other code (4'h0 and 4'h4 to 4'hE) leaves the accumulator, the carry and the output unchanged, and still uses four cycles.
- R6: Code 4'hF raises halted on the edge where that instruction ends. Halted then stays high and the outputs stay frozen until reset. Instructions placed after the halt have no effect.
- R7: With no halt in the program, halted rises when the eighth instruction ends (active edge 32).
- R8: Synchronous active-high reset clears the output register, the carry, the accumulator and halted, and restarts execution at slot 0 in phase T1.
- R9: A program write (prog_we, prog_addr, prog_data) is stored only while run_en is low. A write made while run_en is high is ignored.
- R10: While run_en is low the sequencer holds its phase and its position. When run_en returns high, execution resumes where it stopped.
- R11: The program "load 2, add 1, output" leaves 3 in the output register after exactly twelve run cycles, and 0 after eleven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Lets the phase sequencer advance; program writes are blocked while high |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | $clog2(DEPTH) | Program slot to write |
| prog_data | input | 8 | Instruction word to write |
| out_val | output | ACC_W | Output register |
| carry | output | 1 | Carry from the most recent add |
| halted | output | 1 | Execution has stopped |

## Verification
All results are due on T4 edges. Instruction k commits its output and carry on active edge 4k+4, and halted rises on edge 4n, where n is the number of instructions executed up to and including the halt. The bench counts active edges from the release of reset and samples on the falling edge. It checks the value one edge before each result is due and again on the edge it is due, so an early or late commit shows up as a mismatch. Cycles paused by run_en are not counted, so the pause test expects the result to move later by exactly the paused length. Expected output and carry come from an arithmetic model of the program evaluated at both a wide and a narrow accumulator width.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  localparam int INSTR_W = 8;
  localparam int IMM_W   = 4;

  typedef enum logic [1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2,
    PH_T4 = 2'd3
  } phase_t;

  localparam logic [3:0] OP_LOAD = 4'h1;
  localparam logic [3:0] OP_ADD  = 4'h2;
  localparam logic [3:0] OP_OUT  = 4'h3;
  localparam logic [3:0] OP_HALT = 4'hF;

  typedef struct packed {
    logic [3:0]       op;
    logic [IMM_W-1:0] imm;
  } instr_t;

  typedef struct packed {
    logic wr_acc;
    logic wr_carry;
    logic wr_out;
  } ctrl_t;

endpackage

// File: rtl/qpc_progmem.sv
module qpc_progmem #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto a simple dual-port RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/qpc_sequencer.sv
module qpc_sequencer
  import qpc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          halt_req,
  output phase_t        phase,
  output logic [AW-1:0] pc,
  output logic          halted,
  output logic          step
);

  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic last_q;

  assign step = run_en && !halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_T1;
      pc     <= '0;
      halted <= 1'b0;
      last_q <= 1'b0;
    end else if (step) begin
      unique case (phase)
        PH_T1: phase <= PH_T2;
        PH_T2: begin
          phase <= PH_T3;
          if (pc == LAST_SLOT) begin
            last_q <= 1'b1;
          end else begin
            pc <= pc + 1'b1;
          end
        end
        PH_T3: phase <= PH_T4;
        PH_T4: begin
          phase <= PH_T1;
          if (halt_req || last_q) begin
            halted <= 1'b1;
          end
        end
        default: phase <= PH_T1;
      endcase
    end
  end

endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int ACC_W = 8,
  localparam int SUM_W = ACC_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  phase_t             phase,
  input  logic [INSTR_W-1:0] fetch_word,
  output logic               is_halt,
  output logic [ACC_W-1:0]   out_val,
  output logic               carry
);

  instr_t           ir_q;
  ctrl_t            ctrl;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] res_q;
  logic             cout_q;
  logic [SUM_W-1:0] sum;

  assign sum     = {1'b0, acc_q} + SUM_W'(ir_q.imm);
  assign is_halt = (ir_q.op == OP_HALT);

  always_comb begin
    ctrl = '0;
    unique case (ir_q.op)
      OP_LOAD: ctrl.wr_acc = 1'b1;
      OP_ADD:  begin
        ctrl.wr_acc   = 1'b1;
        ctrl.wr_carry = 1'b1;
      end
      OP_OUT:  ctrl.wr_out = 1'b1;
      default: ctrl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q    <= '0;
      acc_q   <= '0;
      res_q   <= '0;
      cout_q  <= 1'b0;
      out_val <= '0;
      carry   <= 1'b0;
    end else if (step) begin
      unique case (phase)
        PH_T2: ir_q <= instr_t'(fetch_word);
        PH_T3: begin
          if (ir_q.op == OP_LOAD) begin
            res_q  <= ACC_W'(ir_q.imm);
            cout_q <= 1'b0;
          end else begin
            res_q  <= sum[ACC_W-1:0];
            cout_q <= sum[ACC_W];
          end
        end
        PH_T4: begin
          if (ctrl.wr_acc)   acc_q   <= res_q;
          if (ctrl.wr_carry) carry   <= cout_q;
          if (ctrl.wr_out)   out_val <= acc_q;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/quad_phase_cpu.sv
module quad_phase_cpu
  import qpc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ACC_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  output logic [ACC_W-1:0]   out_val,
  output logic               carry,
  output logic               halted
);

  phase_t             phase;
  logic [AW-1:0]      pc;
  logic               step;
  logic               halt_req;
  logic [INSTR_W-1:0] fetch_word;
  logic               mem_we;

  assign mem_we = prog_we && !run_en;

  qpc_progmem #(.DEPTH(DEPTH), .WORD_W(INSTR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc),
    .rdata (fetch_word)
  );

  qpc_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .halt_req (halt_req),
    .phase    (phase),
    .pc       (pc),
    .halted   (halted),
    .step     (step)
  );

  qpc_datapath #(.ACC_W(ACC_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .phase      (phase),
    .fetch_word (fetch_word),
    .is_halt    (halt_req),
    .out_val    (out_val),
    .carry      (carry)
  );

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker
  import qpc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ACC_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input phase_t           phase,
  input logic [AW-1:0]    pc,
  input logic [ACC_W-1:0] out_val,
  input logic             carry,
  input logic             halted
);

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (run_en && !halted && phase == PH_T4) |=> (phase == PH_T1));

  assert_out_on_t4_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(out_val)) |-> ($past(phase) == PH_T4));

  assert_carry_on_t4_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(carry)) |-> ($past(phase) == PH_T4));

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_parked_R6: assert property (@(posedge clk) disable iff (rst)
    halted |-> (phase == PH_T1));

  assert_pause_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> ($stable(phase) && $stable(pc)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (out_val == '0 && !carry && !halted && phase == PH_T1 && pc == '0));

endmodule

bind quad_phase_cpu qpc_checker #(.DEPTH(DEPTH), .ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run_en  (run_en),
  .phase   (phase),
  .pc      (pc),
  .out_val (out_val),
  .carry   (carry),
  .halted  (halted)
);

// File: tb/quad_phase_cpu_tb_top.sv
`timescale 1ns/1ps
module quad_phase_cpu_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic       prog_we = 1'b0;
  logic [2:0] prog_addr = '0;
  logic [7:0] prog_data = '0;
  logic [7:0] out8;
  logic       c8, h8;
  logic [4:0] out5;
  logic       c5, h5;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  quad_phase_cpu #(.DEPTH(8), .ACC_W(8)) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .out_val(out8), .carry(c8), .halted(h8));

  quad_phase_cpu #(.DEPTH(8), .ACC_W(5)) dut_n (
    .clk(clk), .rst(rst), .run_en(run_en), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .out_val(out5), .carry(c5), .halted(h5));

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_prog(input logic [7:0][7:0] p);
    run_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 3'(i); prog_data = p[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  function automatic void model(input logic [7:0][7:0] p, input int w,
                                output int o, output int c, output int n);
    int acc = 0;
    int s;
    o = 0; c = 0; n = 0;
    for (int i = 0; i < 8; i++) begin
      n = i + 1;
      case (p[i][7:4])
        4'h1: acc = int'(p[i][3:0]);
        4'h2: begin
          s = acc + int'(p[i][3:0]);
          c = (s >= (1 << w)) ? 1 : 0;
          acc = s % (1 << w);
        end
        4'h3: o = acc;
        4'hF: break;
        default: ;
      endcase
    end
  endfunction

  // Runs a program from reset; checks halt timing, output and carry on both widths.
  task automatic run_full(input logic [7:0][7:0] p, input string req);
    int o8, k8, n8, o5, k5, n5;
    model(p, 8, o8, k8, n8);
    model(p, 5, o5, k5, n5);
    load_prog(p);
    do_reset();
    run_en = 1'b1;
    edges(4 * n8 - 1);
    check(int'(h8), 0, req, "halted one edge early");
    edges(1);
    check(int'(h8), 1, req, "halted on time (w8)");
    check(int'(h5), 1, req, "halted on time (w5)");
    check(int'(out8), o8, req, "output (w8)");
    check(int'(out5), o5, req, "output (w5)");
    check(int'(c8), k8, req, "carry (w8)");
    check(int'(c5), k5, req, "carry (w5)");
    edges(8);
    check(int'(h8), 1, "R6", "halted stays");
    check(int'(out8), o8, "R6", "output frozen");
    run_en = 1'b0;
  endtask

  function automatic logic [7:0][7:0] fill_halt();
    return {8{8'hF0}};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0][7:0] p;

    // R8: reset state
    edges(3);
    rst = 1'b0;
    edges(1);
    check(int'(out8), 0, "R8", "out after reset");
    check(int'(c8), 0, "R8", "carry after reset");
    check(int'(h8), 0, "R8", "halted after reset");

    // R11 and R1: self-check program timing
    p = fill_halt();
    p[0] = 8'h12; p[1] = 8'h21; p[2] = 8'h30;
    load_prog(p);
    do_reset();
    run_en = 1'b1;
    edges(11);
    check(int'(out8), 0, "R1", "output before T4 of instr 2");
    edges(1);
    check(int'(out8), 3, "R11", "self-check program at cycle 12");
    run_en = 1'b0;

    // R2, R3, R4: sweep of load/add immediates
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        p = fill_halt();
        p[0] = {4'h1, 4'(a)}; p[1] = {4'h2, 4'(b)}; p[2] = 8'h30;
        run_full(p, "R3");
      end
    end

    // R3: carry set on wrap in narrow width, cleared by non-wrapping add
    p = fill_halt();
    p[0] = 8'h1F; p[1] = 8'h2F; p[2] = 8'h2F; p[3] = 8'h30;
    run_full(p, "R3");
    p = fill_halt();
    p[0] = 8'h1F; p[1] = 8'h2F; p[2] = 8'h2F; p[3] = 8'h21; p[4] = 8'h30;
    run_full(p, "R3");

    // R5: unassigned opcodes are no-ops
    p = fill_halt();
    p[0] = 8'h16; p[1] = 8'h4A; p[2] = 8'h0C; p[3] = 8'hE1;
    p[4] = 8'h21; p[5] = 8'h30; p[6] = 8'h95;
    run_full(p, "R5");

    // R6: instructions after halt have no effect
    p = fill_halt();
    p[0] = 8'h12; p[1] = 8'h30; p[2] = 8'hF0; p[3] = 8'h19; p[4] = 8'h30;
    run_full(p, "R6");

    // R7: eight instructions without halt
    p[0] = 8'h11; p[1] = 8'h21; p[2] = 8'h21; p[3] = 8'h21;
    p[4] = 8'h21; p[5] = 8'h21; p[6] = 8'h30; p[7] = 8'h21;
    run_full(p, "R7");

    // R10: pause mid-instruction
    p = fill_halt();
    p[0] = 8'h17; p[1] = 8'h30;
    load_prog(p);
    do_reset();
    run_en = 1'b1;
    edges(5);
    run_en = 1'b0;
    edges(6);
    check(int'(out8), 0, "R10", "output during pause");
    check(int'(h8), 0, "R10", "halted during pause");
    run_en = 1'b1;
    edges(2);
    check(int'(out8), 0, "R10", "output one edge before due");
    edges(1);
    check(int'(out8), 7, "R10", "output after resume");
    run_en = 1'b0;

    // R9: write while running is ignored
    p = fill_halt();
    p[0] = 8'h15; p[1] = 8'h30;
    load_prog(p);
    do_reset();
    run_en = 1'b1;
    prog_we = 1'b1; prog_addr = 3'd1; prog_data = 8'h19;
    edges(3);
    prog_we = 1'b0;
    edges(5);
    check(int'(out8), 5, "R9", "output unaffected by write during run");
    edges(4);
    check(int'(h8), 1, "R9", "halt slot unaffected");

    // R8: reset after a run clears state
    do_reset();
    check(int'(out8), 0, "R8", "out after mid-run reset");
    check(int'(h8), 0, "R8", "halted after mid-run reset");
    run_en = 1'b0;

    // R9: a write with run_en low is kept
    p = fill_halt();
    p[0] = 8'h15; p[1] = 8'h30;
    load_prog(p);
    @(negedge clk); prog_we = 1'b1; prog_addr = 3'd0; prog_data = 8'h1C;
    @(negedge clk); prog_we = 1'b0;
    do_reset();
    run_en = 1'b1;
    edges(8);
    check(int'(out8), 12, "R9", "write while stopped is stored");
    run_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule